// File: doc/BRIEF.md
# SPI Flash Power-State Command Controller

This block is the command front end of a serial memory device. It watches the SPI slave pins through the system clock, assembles 8-bit opcodes most significant bit first, and runs the power-state machine that moves the device between Standby, Active and Deep Power-down. Only two opcodes are acted on. 0xB9 requests deep power-down. 0xAB requests release from it and also returns a one-byte signature on the serial output.

Entry into deep power-down is committed only when chip select rises exactly on the first opcode byte boundary, with no internal write, program or erase cycle running. The low-power enable comes on after a settling delay of `TDP_CYCLES` clocks. While powered down, the block ignores every opcode except release. Release starts a recovery delay of `TRES_CYCLES` clocks, and the block reaches Standby when that delay ends. The serial output is sampled by the master on rising SCK edges and is driven from falling SCK edges. Its enable is low except while a signature is being sent.

Top module: `spi_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_ind` is 0 (Standby), `lp_en` is 0 and `miso_oe` is 0.
- R2: `pwr_ind` uses this encoding:
  - 0 = Standby: chip select high and `busy` low, outside any delay.
  - 1 = Active: chip select low or `busy` high, or during the power-down entry delay.
  - 2 = Deep power-down.
  - 3 = Recovery after release.
- R3: The power-down opcode is 0xB9, sent MSB first. When exactly 8 bits of it are clocked in and chip select then rises, `pwr_ind` becomes 2 and `lp_en` becomes 1 about `TDP_CYCLES` clocks later, and not before. `lp_en` is high only in deep power-down.
- R4: A 0xB9 frame of fewer or more than 8 bits is discarded. So is any other opcode. Either way the state stays out of deep power-down.
- R5: A 0xB9 frame that ends while `busy` is high is rejected. The block stays in Standby/Active, following `busy`.
- R6: In deep power-down, every frame other than one whose first 8 bits are 0xAB leaves `pwr_ind` at 2 and `lp_en` at 1. This includes 0xB9, write and erase opcodes, and a truncated 0xAB.
- R7: When 8 bits of 0xAB have been clocked in during deep power-down, `pwr_ind` becomes 3 and `lp_en` becomes 0 right away. After `TRES_CYCLES` clocks the state returns to Standby.
- R8: A 0xAB frame is followed by three dummy bytes. After them, the parameter `SIGNATURE` (default 0x05) is driven MSB first, one bit per falling SCK edge, and repeats while chip select stays low, with `miso_oe` high. A 0xAB frame in Standby also returns the signature and leaves the state unchanged.
- R9: `miso_oe` is 0 while chip select is high, during the first 32 bits of a release frame, and for every other opcode.
- R10: The bit and byte counters clear when chip select rises. A partial byte in one frame does not shift the opcode of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | SPI serial data into the block |
| busy | input | 1 | High while an internal write, program or erase cycle runs |
| miso | output | 1 | SPI serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso`; low means tri-state |
| lp_en | output | 1 | Low-power enable, high in deep power-down |
| pwr_ind | output | 2 | Power state indication (encoding in R2) |

## Verification
The assertions assume a few things about the inputs:
- `sck`, `cs_n` and `mosi` change slowly compared with `clk`, so every SPI edge is seen by the synchronizers.
- `busy` is driven from the system clock domain.
- No new frame starts while an entry or recovery delay is still running.
- `busy` stays low while the device is powered down.

The stimulus keeps to these assumptions:
- Each SCK half period is eight clocks.
- Every frame is followed by a settle wait longer than both delays.
- `busy` is asserted at random only when the reference model is out of deep power-down, and it is held across the frame and the check.

Random frames mix the two special opcodes with arbitrary bytes and lengths of one to twenty bits. Directed cases cover 7-, 9- and 16-bit power-down frames, a busy rejection, gated opcodes, and both signature paths.

// File: rtl/spi_pwr_pkg.sv
package spi_pwr_pkg;

  // externally visible power indication
  typedef enum logic [1:0] {
    IND_STANDBY = 2'd0,
    IND_ACTIVE  = 2'd1,
    IND_DEEP    = 2'd2,
    IND_WAKE    = 2'd3
  } pwr_ind_t;

  // internal power-state sequencer
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_ENTER = 2'd1,
    PS_DEEP  = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_st_t;

endpackage

// File: rtl/spi_pwr_frontend.sv
module spi_pwr_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_SAT    = 4,
  localparam int BCW        = $clog2(BYTE_SAT + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           sck,
  input  logic           mosi,
  output logic           sel,
  output logic           cs_rise,
  output logic           sck_fall,
  output logic           op_done,
  output logic [7:0]     opcode,
  output logic           one_byte,
  output logic [BCW-1:0] byte_cnt
);

  // each stage holds {cs_n, sck, mosi}
  logic [2:0] sync_q [SYNC_STAGES];
  logic [2:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q[0] <= 3'b100;
    end else begin
      sync_q[0] <= {cs_n, sck, mosi};
    end
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 3'b100;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 3'b100;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic cs_now, sck_now, mosi_now, sck_rise;
  assign cs_now   = sync_q[SYNC_STAGES-1][2];
  assign sck_now  = sync_q[SYNC_STAGES-1][1];
  assign mosi_now = sync_q[SYNC_STAGES-1][0];

  assign sel      = ~cs_now;
  assign cs_rise  = cs_now & ~prev_q[2];
  assign sck_rise = ~cs_now & sck_now & ~prev_q[1];
  assign sck_fall = ~cs_now & ~sck_now & prev_q[1];

  logic [2:0] bit_cnt;
  logic [6:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || cs_now) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      op_done  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_now};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != BCW'(BYTE_SAT)) byte_cnt <= byte_cnt + BCW'(1);
          if (byte_cnt == '0) begin
            opcode  <= {shreg, mosi_now};
            op_done <= 1'b1;
          end
        end
      end
    end
  end

  // chip select rising with exactly one full byte behind it
  assign one_byte = (byte_cnt == BCW'(1)) && (bit_cnt == 3'd0);

  assert_clear_on_deselect_R10: assert property (@(posedge clk) disable iff (rst)
    cs_now |=> (bit_cnt == 3'd0 && byte_cnt == '0 && !op_done));

endmodule

// File: rtl/spi_pwr_fsm.sv
module spi_pwr_fsm
  import spi_pwr_pkg::*;
#(
  parameter int         TDP_CYCLES  = 64,
  parameter int         TRES_CYCLES = 96,
  parameter logic [7:0] OP_PD       = 8'hB9,
  parameter logic [7:0] OP_RES      = 8'hAB,
  localparam int        DMAX        = (TDP_CYCLES > TRES_CYCLES) ? TDP_CYCLES : TRES_CYCLES,
  localparam int        CW          = $clog2(DMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       cs_rise,
  input  logic       one_byte,
  input  logic       op_done,
  input  logic [7:0] opcode,
  input  logic       busy,
  output logic       res_hit,
  output logic       lp_en,
  output logic [1:0] ind
);

  pwr_st_t       st;
  logic [CW-1:0] dly;
  logic          pd_ok;

  assign pd_ok   = cs_rise && one_byte && (opcode == OP_PD) && !busy;
  // release is honoured in normal operation and in deep power-down
  assign res_hit = op_done && (opcode == OP_RES) && (st == PS_RUN || st == PS_DEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_RUN;
      dly <= '0;
    end else begin
      case (st)
        PS_RUN: if (pd_ok) begin
          st  <= PS_ENTER;
          dly <= CW'(TDP_CYCLES - 1);
        end
        PS_ENTER: begin
          if (dly == '0) st <= PS_DEEP;
          else           dly <= dly - CW'(1);
        end
        PS_DEEP: if (res_hit) begin
          st  <= PS_WAKE;
          dly <= CW'(TRES_CYCLES - 1);
        end
        default: begin
          if (dly == '0) st <= PS_RUN;
          else           dly <= dly - CW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ind   <= IND_STANDBY;
      lp_en <= 1'b0;
    end else begin
      lp_en <= (st == PS_DEEP);
      case (st)
        PS_RUN:   ind <= (sel || busy) ? IND_ACTIVE : IND_STANDBY;
        PS_ENTER: ind <= IND_ACTIVE;
        PS_DEEP:  ind <= IND_DEEP;
        default:  ind <= IND_WAKE;
      endcase
    end
  end

  assert_reset_standby_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ind == IND_STANDBY && !lp_en));
  assert_entry_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    (st == PS_ENTER && $past(st) == PS_RUN) |-> $past(cs_rise && one_byte && opcode == OP_PD));
  assert_entry_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (st == PS_ENTER && $past(st) == PS_RUN) |-> $past(!busy));
  assert_deep_exit_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == PS_DEEP && st != PS_DEEP) |-> (st == PS_WAKE && $past(op_done && opcode == OP_RES)));
  assert_lp_only_deep_R3: assert property (@(posedge clk) disable iff (rst)
    lp_en |-> (ind == IND_DEEP));

endmodule

// File: rtl/spi_pwr_sigout.sv
module spi_pwr_sigout #(
  parameter logic [7:0] SIGNATURE = 8'h05,
  parameter int         SIG_START = 4,
  localparam int        BCW       = $clog2(SIG_START + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic           sck_fall,
  input  logic           res_hit,
  input  logic [BCW-1:0] byte_cnt,
  output logic           miso,
  output logic           miso_oe
);

  logic       armed_q;
  logic [2:0] idx;
  logic       stream;

  assign stream = armed_q && (byte_cnt == BCW'(SIG_START));

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      armed_q <= 1'b0;
      idx     <= 3'd7;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      if (res_hit) armed_q <= 1'b1;
      if (sck_fall && stream) begin
        miso    <= SIGNATURE[idx];
        idx     <= idx - 3'd1;
        miso_oe <= 1'b1;
      end
    end
  end

  assert_oe_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !miso_oe);
  assert_oe_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(miso_oe) |-> $past(armed_q && byte_cnt == BCW'(SIG_START) && sck_fall));

endmodule

// File: rtl/spi_pwr_ctrl.sv
module spi_pwr_ctrl #(
  parameter int         SYNC_STAGES = 2,
  parameter int         TDP_CYCLES  = 64,
  parameter int         TRES_CYCLES = 96,
  parameter int         DUMMY_BYTES = 3,
  parameter logic [7:0] SIGNATURE   = 8'h05,
  parameter logic [7:0] OP_PD       = 8'hB9,
  parameter logic [7:0] OP_RES      = 8'hAB
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       busy,
  output logic       miso,
  output logic       miso_oe,
  output logic       lp_en,
  output logic [1:0] pwr_ind
);

  localparam int SIG_START = DUMMY_BYTES + 1;
  localparam int BCW       = $clog2(SIG_START + 1);

  logic           sel, cs_rise, sck_fall, op_done, one_byte, res_hit;
  logic [7:0]     opcode;
  logic [BCW-1:0] byte_cnt;

  spi_pwr_frontend #(
    .SYNC_STAGES (SYNC_STAGES),
    .BYTE_SAT    (SIG_START)
  ) i_frontend (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .sel      (sel),
    .cs_rise  (cs_rise),
    .sck_fall (sck_fall),
    .op_done  (op_done),
    .opcode   (opcode),
    .one_byte (one_byte),
    .byte_cnt (byte_cnt)
  );

  spi_pwr_fsm #(
    .TDP_CYCLES  (TDP_CYCLES),
    .TRES_CYCLES (TRES_CYCLES),
    .OP_PD       (OP_PD),
    .OP_RES      (OP_RES)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .cs_rise  (cs_rise),
    .one_byte (one_byte),
    .op_done  (op_done),
    .opcode   (opcode),
    .busy     (busy),
    .res_hit  (res_hit),
    .lp_en    (lp_en),
    .ind      (pwr_ind)
  );

  spi_pwr_sigout #(
    .SIGNATURE (SIGNATURE),
    .SIG_START (SIG_START)
  ) i_sigout (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .sck_fall (sck_fall),
    .res_hit  (res_hit),
    .byte_cnt (byte_cnt),
    .miso     (miso),
    .miso_oe  (miso_oe)
  );

endmodule

// File: tb/test_spi_pwr_ctrl.sv
module test_spi_pwr_ctrl;

  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 8;
  localparam int         TDP        = 40;
  localparam int         TRES       = 60;
  localparam int         SETTLE     = TDP + TRES + 30;
  localparam logic [7:0] SIG        = 8'h05;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic       miso, miso_oe, lp_en;
  logic [1:0] pwr_ind;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pwr_ctrl #(
    .TDP_CYCLES  (TDP),
    .TRES_CYCLES (TRES),
    .SIGNATURE   (SIG)
  ) i_spi_pwr_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy),
    .miso(miso), .miso_oe(miso_oe), .lp_en(lp_en), .pwr_ind(pwr_ind)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF);
    cs_n = 1'b1;
  endtask

  // shifts n bits MSB first, returns what the master sampled on miso
  task automatic spi_bits(input logic [31:0] val, input int n, output logic [31:0] rd);
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      wait_clk(HALF);
      rd = {rd[30:0], miso};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] val, input int n);
    logic [31:0] rd;
    cs_lo();
    spi_bits(val, n, rd);
    cs_hi();
  endtask

  // reference model: 0 = normal operation, 1 = deep power-down
  function automatic int model_next(input int st, input logic [7:0] op, input int n, input bit bz);
    if (st == 0) return (n == 8 && op == 8'hB9 && !bz) ? 1 : 0;
    return (n >= 8 && op == 8'hAB) ? 0 : 1;
  endfunction

  function automatic logic [1:0] model_ind(input int st, input bit bz);
    if (st == 1) return 2'd2;
    return bz ? 2'd1 : 2'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int st;
    void'($urandom(32'h5EED_0001));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    check("R1", "pwr_ind", pwr_ind, 0);
    check("R1", "lp_en", lp_en, 0);
    check("R1", "miso_oe", miso_oe, 0);

    // R2: selection shows Active, deselection Standby
    cs_n = 1'b0; wait_clk(10);
    check("R2", "ind selected", pwr_ind, 1);
    cs_n = 1'b1; wait_clk(10);
    check("R2", "ind deselected", pwr_ind, 0);

    // R10: partial nibble, then an exact power-down frame
    frame(32'hB, 4);
    wait_clk(10);
    check("R10", "no deep after nibble", lp_en, 0);
    frame(32'hB9, 8);
    wait_clk(TDP / 2);
    check("R3", "ind during entry delay", pwr_ind, 1);
    check("R3", "lp_en during entry delay", lp_en, 0);
    wait_clk(TDP);
    check("R3", "ind deep", pwr_ind, 2);
    check("R10", "lp_en deep after partial frame", lp_en, 1);

    // R6: gated opcodes in deep power-down
    frame(32'h06, 8);  wait_clk(SETTLE);
    check("R6", "write enable ignored", pwr_ind, 2);
    frame(32'hC7, 8);  wait_clk(SETTLE);
    check("R6", "erase ignored", lp_en, 1);
    frame(32'hB9, 8);  wait_clk(SETTLE);
    check("R6", "repeat power-down ignored", pwr_ind, 2);
    frame(32'h55, 7);  wait_clk(SETTLE);
    check("R6", "truncated release ignored", pwr_ind, 2);
    check("R9", "oe for gated frames", miso_oe, 0);

    // R7, R8: release from deep power-down with signature
    cs_lo();
    spi_bits(32'hAB, 8, rd);
    wait_clk(4);
    check("R7", "ind recovery", pwr_ind, 3);
    check("R7", "lp_en off in recovery", lp_en, 0);
    spi_bits(32'h0, 23, rd);
    wait_clk(2);
    check("R9", "oe low before signature", miso_oe, 0);
    spi_bits(32'h0, 1, rd);
    spi_bits(32'h0, 16, rd);
    check("R8", "signature twice", rd[15:0], {SIG, SIG});
    check("R8", "oe during signature", miso_oe, 1);
    cs_hi();
    wait_clk(10);
    check("R9", "oe after deselect", miso_oe, 0);
    check("R7", "standby after recovery", pwr_ind, 0);

    // R8: release in Standby returns signature, state unchanged
    cs_lo();
    spi_bits(32'hAB, 8, rd);
    spi_bits(32'h0, 24, rd);
    spi_bits(32'h0, 8, rd);
    check("R8", "standby signature", rd[7:0], SIG);
    cs_hi();
    wait_clk(SETTLE);
    check("R8", "standby kept", pwr_ind, 0);
    check("R8", "lp_en kept off", lp_en, 0);

    // R4: wrong lengths
    frame(32'h5C, 7);        wait_clk(SETTLE);
    check("R4", "7-bit power-down", pwr_ind, 0);
    frame(32'h173, 9);       wait_clk(SETTLE);
    check("R4", "9-bit power-down", pwr_ind, 0);
    frame(32'hB900, 16);     wait_clk(SETTLE);
    check("R4", "16-bit power-down", lp_en, 0);

    // R5: busy rejects entry
    busy = 1'b1;
    frame(32'hB9, 8);        wait_clk(SETTLE);
    check("R5", "busy rejects entry ind", pwr_ind, 1);
    check("R5", "busy rejects entry lp", lp_en, 0);
    busy = 1'b0;
    wait_clk(5);
    check("R2", "standby after busy", pwr_ind, 0);

    // random frames against the model
    st = 0;
    for (int it = 0; it < 60; it++) begin
      logic [7:0] op;
      int n;
      logic [31:0] val;
      bit bz;
      case ($urandom % 4)
        0: op = 8'hB9;
        1: op = 8'hAB;
        default: op = 8'($urandom);
      endcase
      case ($urandom % 4)
        0: n = 8;
        1: n = 7;
        2: n = 9;
        default: n = 1 + int'($urandom % 20);
      endcase
      if (n >= 8) val = (32'(op) << (n - 8)) | (32'($urandom) & ((32'd1 << (n - 8)) - 1));
      else        val = 32'(op) >> (8 - n);
      bz = (st == 0) && ($urandom % 3 == 0);
      busy = bz;
      frame(val, n);
      wait_clk(SETTLE);
      st = model_next(st, op, n, bz);
      check(st == 1 ? "R6" : "R4", "random ind", pwr_ind, model_ind(st, bz));
      check("R3", "random lp_en", lp_en, (st == 1) ? 1 : 0);
      busy = 1'b0;
      wait_clk(4);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule